// File: doc/BRIEF.md
# Link Control Register with Set/Clear Ports

This block is the control register of a serial-bus link layer. It holds five flags that steer the cycle timer and the packet receiver. Software writes the flags through two addresses. A write to the set address turns bits on. A write to the clear address turns bits off. Reading either address returns the current flags. A separate 8-bit priority-request budget register sits beside them on the same simple register bus. Each flag and the budget also drive a decoded output.

The cycle-master flag has hardware protection. While the cycle-too-long event input is high, hardware holds that flag at zero and ignores any attempt to set it. The block has two resets. The asynchronous hardware reset zeroes everything. The synchronous software reset clears every flag except the cycle-source selector, and it does not touch the budget.

Top module: `link_ctrl_regs`

## Requirements
- R1: After hardware reset (`rst_ni` low), every flag output and `budget_o` is 0, and reads of offsets DCh, E0h and E4h all return 0.
- R2: A write to offset E0h sets each flag whose bit in `wdata_i` is one and leaves the other flags unchanged. The bit positions are cycle source 22, cycle master 21, timer enable 20, PHY-packet receive 10 and self-ID receive 9.
- R3: A write to offset E4h clears each flag whose bit in `wdata_i` is one, using the same bit positions, and leaves the other flags unchanged.
- R4: A read of offset E0h or offset E4h returns the five flags at bits 22, 21, 20, 10 and 9.
- R5: Every other bit of a read from E0h or E4h is zero. Write-data ones at those bits have no effect.
- R6: Offset DCh holds an 8-bit read/write budget in bits 7:0, which also drives `budget_o`. Bits 31:8 read as zero.
- R7: While `cyc_too_long_i` is high, the cycle-master flag is zero from the following clock edge on. A set write issued in that state cannot set it, including in the same cycle that the input rises. The other bits of that write still take effect.
- R8: Once `cyc_too_long_i` is low again, a set write can set cycle master.
- R9: A software reset (`sw_rst_i` high at a clock edge) clears cycle master, timer enable, PHY-packet receive and self-ID receive. It keeps cycle source and the budget. It overrides a register write in the same cycle.
- R10: Reads of any offset other than DCh, E0h and E4h return zero, and writes to those offsets change neither the flags nor the budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| sw_rst_i | input | 1 | Synchronous software reset |
| addr_i | input | 8 | Byte offset of the access |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| cyc_too_long_i | input | 1 | Cycle-too-long event flag |
| cyc_src_o | output | 1 | Cycle timer driven by an external event |
| cyc_master_o | output | 1 | Node acts as cycle master |
| cyc_tmr_en_o | output | 1 | Cycle timer counting enabled |
| rx_phy_pkt_o | output | 1 | Accept PHY packets |
| rx_self_id_o | output | 1 | Accept self-ID packets |
| budget_o | output | 8 | Priority-request budget per fairness interval |

## Verification
The set and clear paths are each swept over all 32 flag patterns. Each set is followed by a clear with a rotated pattern, which separates OR/AND-NOT behaviour from plain overwrite and catches bit positions that are swapped or missing. Ones in the reserved write bits show whether reserved storage leaks through. The budget is swept over all 256 values with its upper bits driven high. Every unmapped word offset is written with all ones and read back. The cycle-too-long and software-reset sequences are run with the flag set both before the event and in the same cycle as the write, and with cycle source at 0 and at 1.

// File: rtl/link_ctrl_pkg.sv
package link_ctrl_pkg;
  localparam int unsigned NFLAG = 5;
  // flag index -> word bit position (software decodes these)
  localparam int FLAG_POS [NFLAG] = '{9, 10, 20, 21, 22};
  localparam int IDX_SID = 0;
  localparam int IDX_PHY = 1;
  localparam int IDX_TEN = 2;
  localparam int IDX_MST = 3;
  localparam int IDX_SRC = 4;

  localparam logic [7:0] OFS_BUDGET = 8'hDC;
  localparam logic [7:0] OFS_SET    = 8'hE0;
  localparam logic [7:0] OFS_CLR    = 8'hE4;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_BUDGET,
    ACC_SET,
    ACC_CLR
  } acc_e;
endpackage

// File: rtl/link_ctrl_decode.sv
module link_ctrl_decode
  import link_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output acc_e              sel_o
);
  always_comb begin
    if (addr_i == ADDR_W'(OFS_BUDGET))   sel_o = ACC_BUDGET;
    else if (addr_i == ADDR_W'(OFS_SET)) sel_o = ACC_SET;
    else if (addr_i == ADDR_W'(OFS_CLR)) sel_o = ACC_CLR;
    else                                 sel_o = ACC_NONE;
  end
endmodule

// File: rtl/link_ctrl_flags.sv
module link_ctrl_flags
  import link_ctrl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sw_rst_i,
  input  logic             set_we_i,
  input  logic             clr_we_i,
  input  logic [NFLAG-1:0] wbits_i,
  input  logic             ctl_i,
  output logic [NFLAG-1:0] flags_o
);
  logic [NFLAG-1:0] flags_q, flags_d;

  always_comb begin
    flags_d = flags_q;
    if (set_we_i) flags_d = flags_d | wbits_i;
    if (clr_we_i) flags_d = flags_d & ~wbits_i;
    if (ctl_i)    flags_d[IDX_MST] = 1'b0;  // auto-clear beats set
    if (sw_rst_i) begin
      flags_d          = '0;
      flags_d[IDX_SRC] = flags_q[IDX_SRC];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/link_ctrl_budget.sv
module link_ctrl_budget #(
  parameter int unsigned BUDGET_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [BUDGET_W-1:0] wdata_i,
  output logic [BUDGET_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/link_ctrl_regs.sv
module link_ctrl_regs
  import link_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned BUDGET_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sw_rst_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic                cyc_too_long_i,
  output logic                cyc_src_o,
  output logic                cyc_master_o,
  output logic                cyc_tmr_en_o,
  output logic                rx_phy_pkt_o,
  output logic                rx_self_id_o,
  output logic [BUDGET_W-1:0] budget_o
);
  acc_e             sel;
  logic [NFLAG-1:0] wbits;
  logic [NFLAG-1:0] flags;
  logic [DATA_W-1:0] flag_word;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i;

  link_ctrl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  for (genvar g = 0; g < NFLAG; g++) begin : g_wbit
    assign wbits[g] = wdata_i[FLAG_POS[g]];
  end

  link_ctrl_flags u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sw_rst_i (sw_rst_i),
    .set_we_i (wr_en_i && sel == ACC_SET),
    .clr_we_i (wr_en_i && sel == ACC_CLR),
    .wbits_i  (wbits),
    .ctl_i    (cyc_too_long_i),
    .flags_o  (flags)
  );

  link_ctrl_budget #(.BUDGET_W(BUDGET_W)) u_budget (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i && sel == ACC_BUDGET && !sw_rst_i),
    .wdata_i (wdata_i[BUDGET_W-1:0]),
    .q_o     (budget_o)
  );

  always_comb begin
    flag_word = '0;
    for (int i = 0; i < NFLAG; i++) flag_word[FLAG_POS[i]] = flags[i];
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      ACC_BUDGET:       rdata_o[BUDGET_W-1:0] = budget_o;
      ACC_SET, ACC_CLR: rdata_o = flag_word;
      default:          rdata_o = '0;
    endcase
  end

  assign cyc_src_o    = flags[IDX_SRC];
  assign cyc_master_o = flags[IDX_MST];
  assign cyc_tmr_en_o = flags[IDX_TEN];
  assign rx_phy_pkt_o = flags[IDX_PHY];
  assign rx_self_id_o = flags[IDX_SID];
endmodule

// File: rtl/link_ctrl_regs_chk.sv
module link_ctrl_regs_chk
  import link_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned BUDGET_W = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                sw_rst_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic                wr_en_i,
  input logic [DATA_W-1:0]   wdata_i,
  input logic [DATA_W-1:0]   rdata_o,
  input logic                cyc_too_long_i,
  input logic                cyc_src_o,
  input logic                cyc_master_o,
  input logic                cyc_tmr_en_o,
  input logic                rx_phy_pkt_o,
  input logic                rx_self_id_o,
  input logic [BUDGET_W-1:0] budget_o
);
  logic [NFLAG-1:0]  ctl_v;
  logic [NFLAG-1:0]  wm;
  logic [DATA_W-1:0] rsvd_mask;
  logic              set_wr, clr_wr, map_hit;

  assign ctl_v = {cyc_src_o, cyc_master_o, cyc_tmr_en_o, rx_phy_pkt_o, rx_self_id_o};

  always_comb begin
    rsvd_mask = '1;
    for (int i = 0; i < NFLAG; i++) begin
      wm[i] = wdata_i[FLAG_POS[i]];
      rsvd_mask[FLAG_POS[i]] = 1'b0;
    end
  end

  assign set_wr  = wr_en_i && addr_i == ADDR_W'(OFS_SET);
  assign clr_wr  = wr_en_i && addr_i == ADDR_W'(OFS_CLR);
  assign map_hit = addr_i == ADDR_W'(OFS_SET) || addr_i == ADDR_W'(OFS_CLR) ||
                   addr_i == ADDR_W'(OFS_BUDGET);

  p_set_or_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_wr && !sw_rst_i && !cyc_too_long_i |=> ctl_v == ($past(ctl_v) | $past(wm)));

  p_clr_andn_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr && !sw_rst_i && !cyc_too_long_i |=> ctl_v == ($past(ctl_v) & ~$past(wm)));

  p_rsvd_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(OFS_SET) || addr_i == ADDR_W'(OFS_CLR)) |-> (rdata_o & rsvd_mask) == '0);

  p_budget_hi_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == ADDR_W'(OFS_BUDGET) |-> rdata_o[DATA_W-1:BUDGET_W] == '0);

  p_mst_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_too_long_i |=> !cyc_master_o);

  p_swrst_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_rst_i |=> ctl_v[IDX_MST:0] == '0 && cyc_src_o == $past(cyc_src_o) && $stable(budget_o));

  p_unmapped_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !map_hit && !sw_rst_i && !cyc_too_long_i |=> $stable(ctl_v) && $stable(budget_o));

  p_unmapped_rd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !map_hit |-> rdata_o == '0);
endmodule

bind link_ctrl_regs link_ctrl_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUDGET_W(BUDGET_W)
) chk_i (.*);

// File: tb/link_ctrl_regs_tb_top.sv
module link_ctrl_regs_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sw_rst_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        cyc_too_long_i = 1'b0;
  logic        cyc_src_o, cyc_master_o, cyc_tmr_en_o, rx_phy_pkt_o, rx_self_id_o;
  logic [7:0]  budget_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  link_ctrl_regs dut_i (.*);

  // flag pattern bit4..0 = source, master, timer, phy, selfid
  function automatic logic [31:0] spread(input logic [4:0] m);
    logic [31:0] w = '0;
    w[22] = m[4]; w[21] = m[3]; w[20] = m[2]; w[10] = m[1]; w[9] = m[0];
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; addr_i = 8'h00;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk_i);
    addr_i = a;
    #1;
    check(req, rdata_o, exp);
    addr_i = 8'h00;
  endtask

  function automatic logic [31:0] outs();
    return spread({cyc_src_o, cyc_master_o, cyc_tmr_en_o, rx_phy_pkt_o, rx_self_id_o});
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    check("R1 outs", outs(), 32'h0);
    check("R1 budget", {24'h0, budget_o}, 32'h0);
    rst_ni = 1'b1;
    rd_chk("R1 DC", 8'hDC, 32'h0);
    rd_chk("R1 E0", 8'hE0, 32'h0);
    rd_chk("R1 E4", 8'hE4, 32'h0);

    // R2/R3/R4/R5: full set/clear sweep, reserved ones in write data
    for (int m = 0; m < 32; m++) begin
      logic [4:0] c;
      bus_wr(8'hE4, 32'hFFFF_FFFF);
      rd_chk("R3 clear all", 8'hE0, 32'h0);
      bus_wr(8'hE0, spread(5'(m)) | (32'hA5A5_A5A5 & ~spread(5'h1F)));
      rd_chk("R2 set E0", 8'hE0, spread(5'(m)));
      rd_chk("R4 read E4", 8'hE4, spread(5'(m)));
      check("R5 outs", outs(), spread(5'(m)));
      c = {m[0], m[4:1]} ^ 5'b01010;
      bus_wr(8'hE0, spread(5'h0));
      rd_chk("R2 set zero no effect", 8'hE0, spread(5'(m)));
      bus_wr(8'hE4, spread(c) | 32'h5A00_0000);
      rd_chk("R3 clear partial", 8'hE0, spread(5'(m) & ~c));
    end

    // R6: budget sweep
    for (int v = 0; v < 256; v++) begin
      bus_wr(8'hDC, 32'hFFFF_FF00 | 32'(v));
      rd_chk("R6 budget rd", 8'hDC, 32'(v));
      check("R6 budget out", {24'h0, budget_o}, 32'(v));
    end

    // R10: unmapped offsets
    bus_wr(8'hE4, 32'hFFFF_FFFF);
    bus_wr(8'hE0, spread(5'b10101));
    bus_wr(8'hDC, 32'h0000_003C);
    for (int a = 0; a < 256; a += 4) begin
      if (a != 'hDC && a != 'hE0 && a != 'hE4) begin
        bus_wr(8'(a), 32'hFFFF_FFFF);
        rd_chk("R10 unmapped read", 8'(a), 32'h0);
      end
    end
    rd_chk("R10 flags intact", 8'hE0, spread(5'b10101));
    rd_chk("R10 budget intact", 8'hDC, 32'h3C);

    // R7/R8: cycle-too-long lock
    bus_wr(8'hE0, spread(5'h1F));
    @(negedge clk_i); cyc_too_long_i = 1'b1;
    @(negedge clk_i);
    check("R7 auto-clear", {31'h0, cyc_master_o}, 32'h0);
    bus_wr(8'hE4, spread(5'b00111));
    bus_wr(8'hE0, spread(5'h1F));
    rd_chk("R7 set blocked", 8'hE0, spread(5'b10111));
    @(negedge clk_i); cyc_too_long_i = 1'b0;
    bus_wr(8'hE0, spread(5'b01000));
    rd_chk("R8 set after release", 8'hE0, spread(5'h1F));
    // same-cycle rise and set write
    bus_wr(8'hE4, 32'hFFFF_FFFF);
    @(negedge clk_i);
    addr_i = 8'hE0; wdata_i = spread(5'h1F); wr_en_i = 1'b1; cyc_too_long_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; cyc_too_long_i = 1'b0; addr_i = 8'h00;
    rd_chk("R7 same cycle", 8'hE0, spread(5'b10111));

    // R9: software reset, with source 1 and 0, write in same cycle
    for (int s = 0; s < 2; s++) begin
      bus_wr(8'hE4, 32'hFFFF_FFFF);
      bus_wr(8'hE0, spread({s[0], 4'hF}));
      bus_wr(8'hDC, 32'h5A);
      @(negedge clk_i);
      sw_rst_i = 1'b1; addr_i = 8'hE0; wdata_i = 32'hFFFF_FFFF; wr_en_i = 1'b1;
      @(negedge clk_i);
      sw_rst_i = 1'b0; wr_en_i = 1'b0; addr_i = 8'h00;
      rd_chk("R9 sw reset flags", 8'hE0, spread({s[0], 4'h0}));
      rd_chk("R9 budget kept", 8'hDC, 32'h5A);
      @(negedge clk_i);
      sw_rst_i = 1'b1; addr_i = 8'hDC; wdata_i = 32'h11; wr_en_i = 1'b1;
      @(negedge clk_i);
      sw_rst_i = 1'b0; wr_en_i = 1'b0; addr_i = 8'h00;
      rd_chk("R9 budget write blocked", 8'hDC, 32'h5A);
    end

    // R1: hardware reset again clears everything, including source
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 hw reset outs", outs(), 32'h0);
    check("R1 hw reset budget", {24'h0, budget_o}, 32'h0);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule